// File: doc/BRIEF.md
# Full-speed USB IN endpoint transmit sequencer

This block answers IN tokens for one endpoint of a full-speed USB device. When a token arrives and the endpoint is armed, it reads a two-word transmit descriptor from a 16-bit packet memory. The first word is the byte start address of the payload and the second is the byte count. It prefetches the first payload word and offers a DATA0 or DATA1 PID on a byte stream, followed by the payload bytes and then one beat that asks the serializer to append the CRC. The sequencer itself computes no CRC, does no bit stuffing and does no line coding.

When the endpoint is not armed, the block answers with a single handshake beat (NAK or STALL), or with nothing if the endpoint is disabled. After a data packet it opens an acknowledge window. A host ACK inside that window flips the data toggle, drops the endpoint back to NAK and raises the transfer-complete flag. If no ACK arrives, the endpoint stays as it was, so the host can retry. Software re-arms the endpoint through the arm strobe and clears the complete flag through its own strobe.

Outgoing beats use a valid/ready stream. A beat that is offered stays unchanged until it is accepted, and the serializer may hold `tx_ready` low for as long as it needs without losing or reordering anything.

Top module: `usb_in_tx_seq`

## Requirements
- R1: After reset the endpoint status reads 2'b00 (disabled), the toggle is 0, the complete flag is 0 and no beat is offered.
- R2: With status 2'b11 (armed), a token produces one PID beat (0xC3 when the toggle is 0, 0x4B when it is 1), then the payload bytes, then one beat with `tx_crc`=1, `tx_last`=1 and byte 0x00. Only that final beat carries `tx_last`.
- R3: The descriptor lives at word `DESC_WADDR` (payload byte address; bit 0 ignored) and word `DESC_WADDR`+1 (byte count in the low `CNT_W` bits). The payload comes from consecutive words starting at address>>1, with the low byte of each word sent first. With an odd count, only the low byte of the last word is sent.
- R4: A byte count of zero yields the PID beat directly followed by the CRC beat.
- R5: With status 2'b10 a token is answered by one beat 0x5A with `tx_last`=1. With status 2'b01 the beat is 0x1E. In both cases status, toggle and complete flag are left unchanged.
- R6: With status 2'b00 a token produces no beat and no memory read.
- R7: An `ack_in` pulse within `ACK_WIN` cycles after the CRC beat is accepted inverts the toggle, sets status to 2'b10 and sets the complete flag.
- R8: If no ACK comes within the window, status, toggle and complete flag are unchanged. An ACK after the window, or one that does not follow a data packet, is ignored.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte`, `tx_crc` and `tx_last` hold their values. Any ready pattern yields the same beat sequence.
- R10: A token that arrives while a packet is in progress or the ACK window is open is ignored.
- R11: `arm_we` loads status and toggle from `arm_stat`/`arm_tog`. `done_clr` clears the complete flag. An ACK update in the same cycle wins over both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in | input | 1 | One-cycle strobe: IN token for this endpoint |
| ack_in | input | 1 | One-cycle strobe: host ACK handshake received |
| arm_we | input | 1 | Load endpoint status and toggle |
| arm_stat | input | 2 | Status to load (00 disabled, 01 stall, 10 nak, 11 armed) |
| arm_tog | input | 1 | Toggle to load |
| done_clr | input | 1 | Clear the complete flag |
| mem_rd_en | output | 1 | Packet memory read request |
| mem_addr | output | AW | Packet memory word address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| tx_valid | output | 1 | Beat offered |
| tx_ready | input | 1 | Serializer accepts the beat |
| tx_byte | output | 8 | PID, payload or handshake byte |
| tx_crc | output | 1 | Beat is a request to append the CRC |
| tx_last | output | 1 | Final beat of the packet |
| ep_stat | output | 2 | Current endpoint transmit status |
| ep_tog | output | 1 | Current transmit data toggle |
| xfer_done | output | 1 | Transfer-complete flag |

## Verification
Some internal faults show up on the stream within one beat of the token. A corrupt descriptor address or a wrong low/high byte selection sends wrong payload bytes. A wrong remaining-byte count moves the CRC beat earlier or later. A wrong PID choice is visible in the first beat. Faults in the acknowledge window or the status register do not touch the stream, so they appear only in `ep_stat`, `ep_tog` and `xfer_done` once the window has closed, and in the reply to the next token, which must be NAK after a good ACK. Running every packet shape both with ready held high and with ready throttled exposes any beat that changes or is lost while stalled.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  localparam logic [1:0] ST_DIS   = 2'b00;
  localparam logic [1:0] ST_STALL = 2'b01;
  localparam logic [1:0] ST_NAK   = 2'b10;
  localparam logic [1:0] ST_VALID = 2'b11;

  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] PID_STALL = 8'h1E;

  typedef enum logic [3:0] {
    S_IDLE, S_DADR, S_DCNT, S_WREQ, S_WGET,
    S_PID, S_DATA, S_FETCH, S_CRC, S_WAIT, S_HS
  } seq_state_e;
endpackage

// File: rtl/usb_in_epstate.sv
module usb_in_epstate
  import usb_in_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_we,
  input  logic [1:0] arm_stat,
  input  logic       arm_tog,
  input  logic       done_clr,
  input  logic       ack_apply,
  output logic [1:0] ep_stat,
  output logic       ep_tog,
  output logic       done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_stat <= ST_DIS;
      ep_tog  <= 1'b0;
      done    <= 1'b0;
    end else if (ack_apply) begin
      ep_stat <= ST_NAK;
      ep_tog  <= ~ep_tog;
      done    <= 1'b1;
    end else begin
      if (arm_we) begin
        ep_stat <= arm_stat;
        ep_tog  <= arm_tog;
      end
      if (done_clr) done <= 1'b0;
    end
  end

  // R7: acknowledged packet flips toggle, drops to NAK, flags completion
  a_r7_ack_update: assert property (@(posedge clk) disable iff (!rst_n)
    ack_apply |=> (ep_stat == ST_NAK) && done && (ep_tog != $past(ep_tog)));

  // R11: arm strobe loads status and toggle when no ACK competes
  a_r11_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_we && !ack_apply) |=> (ep_stat == $past(arm_stat)) && (ep_tog == $past(arm_tog)));

  // R5/R8: without arm or ACK the endpoint state stays put
  a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_we && !ack_apply) |=> $stable(ep_stat) && $stable(ep_tog));
endmodule

// File: rtl/usb_in_ackwin.sv
module usb_in_ackwin #(
  parameter int ACK_WIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_in,
  output logic open,
  output logic ack_hit
);
  localparam int CW = $clog2(ACK_WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_WIN - 1);

  logic [CW-1:0] cnt;

  assign ack_hit = open && ack_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      open <= 1'b1;
      cnt  <= '0;
    end else if (open) begin
      if (ack_in || cnt == LAST) open <= 1'b0;
      else                       cnt  <= cnt + 1'b1;
    end
  end

  // R8: window never outlives its length
  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> (cnt < CW'(ACK_WIN)));

  // R7: an accepted ACK closes the window
  a_r7_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !start) |=> !open);
endmodule

// File: rtl/usb_in_seq.sv
module usb_in_seq
  import usb_in_pkg::*;
#(
  parameter int AW         = 9,
  parameter int CNT_W      = 10,
  parameter int DESC_WADDR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_in,
  input  logic [1:0]    ep_stat,
  input  logic          ep_tog,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_byte,
  output logic          tx_crc,
  output logic          tx_last,
  output logic          win_start,
  input  logic          win_open
);
  localparam logic [AW-1:0] DESC_A = AW'(DESC_WADDR);
  localparam logic [AW-1:0] DESC_B = AW'(DESC_WADDR + 1);

  seq_state_e       state;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] remain;
  logic [15:0]      wbuf;
  logic             hi;
  logic [7:0]       pid_r;
  logic [7:0]       hs_r;
  logic             fire;

  assign fire = tx_valid && tx_ready;

  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = ptr;
    tx_valid  = 1'b0;
    tx_byte   = 8'h00;
    tx_crc    = 1'b0;
    tx_last   = 1'b0;
    win_start = 1'b0;
    unique case (state)
      S_DADR: begin mem_rd_en = 1'b1; mem_addr = DESC_A; end
      S_DCNT: begin mem_rd_en = 1'b1; mem_addr = DESC_B; end
      S_WREQ: mem_rd_en = (mem_rdata[CNT_W-1:0] != '0);
      S_PID:  begin tx_valid = 1'b1; tx_byte = pid_r; end
      S_DATA: begin
        tx_valid  = 1'b1;
        tx_byte   = hi ? wbuf[15:8] : wbuf[7:0];
        mem_rd_en = fire && hi && (remain != CNT_W'(1));
      end
      S_CRC:  begin
        tx_valid = 1'b1; tx_crc = 1'b1; tx_last = 1'b1;
        win_start = tx_ready;
      end
      S_HS:   begin tx_valid = 1'b1; tx_byte = hs_r; tx_last = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      remain <= '0;
      wbuf   <= '0;
      hi     <= 1'b0;
      pid_r  <= PID_DATA0;
      hs_r   <= PID_NAK;
    end else begin
      unique case (state)
        S_IDLE: if (tok_in) begin
          unique case (ep_stat)
            ST_VALID: begin
              state <= S_DADR;
              pid_r <= ep_tog ? PID_DATA1 : PID_DATA0;
            end
            ST_NAK:   begin state <= S_HS; hs_r <= PID_NAK;   end
            ST_STALL: begin state <= S_HS; hs_r <= PID_STALL; end
            default:  ;
          endcase
        end
        S_DADR: state <= S_DCNT;
        S_DCNT: begin
          ptr   <= mem_rdata[AW:1];
          state <= S_WREQ;
        end
        S_WREQ: begin
          remain <= mem_rdata[CNT_W-1:0];
          state  <= (mem_rdata[CNT_W-1:0] == '0) ? S_PID : S_WGET;
        end
        S_WGET: begin
          wbuf  <= mem_rdata;
          ptr   <= ptr + 1'b1;
          hi    <= 1'b0;
          state <= S_PID;
        end
        S_PID: if (fire) state <= (remain == '0) ? S_CRC : S_DATA;
        S_DATA: if (fire) begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) begin
            state <= S_CRC;
          end else if (hi) begin
            ptr   <= ptr + 1'b1;
            hi    <= 1'b0;
            state <= S_FETCH;
          end else begin
            hi <= 1'b1;
          end
        end
        S_FETCH: begin
          wbuf  <= mem_rdata;
          state <= S_DATA;
        end
        S_CRC:  if (fire) state <= S_WAIT;
        S_WAIT: if (!win_open) state <= S_IDLE;
        S_HS:   if (fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: an offered beat is held until it is taken
  a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte) && $stable(tx_crc) && $stable(tx_last));

  // R4: empty payload goes from PID straight to the CRC request
  a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PID && fire && remain == '0) |=> tx_valid && tx_crc);

  // R6: disabled endpoint stays silent and leaves memory alone
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tok_in && ep_stat == ST_DIS) |=> !tx_valid && !mem_rd_en);

  // R10: token while busy does not restart the sequence
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CRC && !tx_ready && tok_in) |=> (state == S_CRC));
endmodule

// File: rtl/usb_in_tx_seq.sv
module usb_in_tx_seq #(
  parameter int AW         = 9,
  parameter int CNT_W      = 10,
  parameter int DESC_WADDR = 0,
  parameter int ACK_WIN    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_in,
  input  logic          ack_in,
  input  logic          arm_we,
  input  logic [1:0]    arm_stat,
  input  logic          arm_tog,
  input  logic          done_clr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_byte,
  output logic          tx_crc,
  output logic          tx_last,
  output logic [1:0]    ep_stat,
  output logic          ep_tog,
  output logic          xfer_done
);
  logic win_start;
  logic win_open;
  logic ack_hit;

  usb_in_seq #(.AW(AW), .CNT_W(CNT_W), .DESC_WADDR(DESC_WADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok_in),
    .ep_stat   (ep_stat),
    .ep_tog    (ep_tog),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .tx_crc    (tx_crc),
    .tx_last   (tx_last),
    .win_start (win_start),
    .win_open  (win_open)
  );

  usb_in_ackwin #(.ACK_WIN(ACK_WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (win_start),
    .ack_in  (ack_in),
    .open    (win_open),
    .ack_hit (ack_hit)
  );

  usb_in_epstate u_ep (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_we    (arm_we),
    .arm_stat  (arm_stat),
    .arm_tog   (arm_tog),
    .done_clr  (done_clr),
    .ack_apply (ack_hit),
    .ep_stat   (ep_stat),
    .ep_tog    (ep_tog),
    .done      (xfer_done)
  );
endmodule

// File: tb/test_usb_in_tx_seq.sv
module test_usb_in_tx_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int ACK_WIN = 32;

  typedef struct packed {
    logic [1:0]  st;
    logic        tg;
    logic [15:0] addr;
    logic [15:0] cnt;
    logic [1:0]  ackm;   // 0 none, 1 in window, 2 late
    logic        thr;
    logic [7:0]  xn;     // expected beat count
    logic [7:0]  xfirst; // expected first byte
    logic [1:0]  xst;    // expected status afterwards
    logic        xflip;  // toggle inverted and done set
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 16'h0020, 16'd4, 2'd1, 1'b0, 8'd6, 8'hC3, 2'b10, 1'b1},
    '{2'b11, 1'b1, 16'h0040, 16'd5, 2'd1, 1'b1, 8'd7, 8'h4B, 2'b10, 1'b1},
    '{2'b11, 1'b0, 16'h0061, 16'd0, 2'd1, 1'b0, 8'd2, 8'hC3, 2'b10, 1'b1},
    '{2'b11, 1'b1, 16'h0080, 16'd3, 2'd2, 1'b1, 8'd5, 8'h4B, 2'b11, 1'b0},
    '{2'b11, 1'b0, 16'h0090, 16'd2, 2'd0, 1'b0, 8'd4, 8'hC3, 2'b11, 1'b0},
    '{2'b10, 1'b1, 16'h0020, 16'd4, 2'd1, 1'b0, 8'd1, 8'h5A, 2'b10, 1'b0},
    '{2'b01, 1'b0, 16'h0020, 16'd4, 2'd1, 1'b1, 8'd1, 8'h1E, 2'b01, 1'b0},
    '{2'b00, 1'b1, 16'h0020, 16'd4, 2'd1, 1'b0, 8'd0, 8'h00, 2'b00, 1'b0},
    '{2'b11, 1'b0, 16'h0023, 16'd1, 2'd1, 1'b1, 8'd3, 8'hC3, 2'b10, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_in = 1'b0, ack_in = 1'b0, arm_we = 1'b0, arm_tog = 1'b0, done_clr = 1'b0;
  logic [1:0] arm_stat = 2'b00;
  logic mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b1, tx_crc, tx_last, ep_tog, xfer_done;
  logic [7:0] tx_byte;
  logic [1:0] ep_stat;

  logic [15:0] mem [0:(1<<AW)-1];
  logic [9:0]  beats [0:63];
  int nb = 0;
  logic seen_last = 1'b0;
  logic throttle = 1'b0;
  int cyc = 0;
  int nrd = 0;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_tx_seq #(.AW(AW), .ACK_WIN(ACK_WIN)) i_usb_in_tx_seq (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .ack_in(ack_in),
    .arm_we(arm_we), .arm_stat(arm_stat), .arm_tog(arm_tog), .done_clr(done_clr),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_crc(tx_crc), .tx_last(tx_last),
    .ep_stat(ep_stat), .ep_tog(ep_tog), .xfer_done(xfer_done)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      nrd = nrd + 1;
    end
    if (rst_n && tx_valid && tx_ready) begin
      if (nb < 64) beats[nb] = {tx_crc, tx_last, tx_byte};
      nb = nb + 1;
      if (tx_last) seen_last = 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    tx_ready <= throttle ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input logic [15:0] a, input int k);
    logic [15:0] w;
    w = mem[AW'((a >> 1) + 16'(k >> 1))];
    return k[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic arm(input logic [1:0] s, input logic t);
    @(negedge clk);
    arm_we = 1'b1; arm_stat = s; arm_tog = t; done_clr = 1'b1;
    @(negedge clk);
    arm_we = 1'b0; done_clr = 1'b0;
  endtask

  task automatic pulse_tok;
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0;
  endtask

  // Sends one transaction and waits until the acknowledge window has closed
  task automatic run(input vec_t v, input bit extra_tok);
    arm(v.st, v.tg);
    mem[0] = v.addr;
    mem[1] = v.cnt;
    throttle = v.thr;
    @(negedge clk);
    nb = 0; seen_last = 1'b0; nrd = 0;
    pulse_tok;
    if (extra_tok) begin
      repeat (2) @(negedge clk);
      pulse_tok;
    end
    for (int i = 0; i < 300 && !seen_last; i++) @(negedge clk);
    if (extra_tok) pulse_tok;
    repeat (2) @(negedge clk);
    if (v.ackm == 2'd1) pulse_ack;
    if (v.ackm == 2'd2) begin
      repeat (ACK_WIN + 5) @(negedge clk);
      pulse_ack;
    end
    repeat (ACK_WIN + 8) @(negedge clk);
    throttle = 1'b0;
  endtask

  task automatic judge(input vec_t v, input string req);
    int bad;
    int exp_n;
    exp_n = int'(v.xn);
    chk(nb == exp_n, {req, " beat count"}, nb, exp_n);
    if (exp_n > 0)
      chk(beats[0][7:0] == v.xfirst, {req, " first byte"}, beats[0][7:0], v.xfirst);
    if (v.st == 2'b11 && nb == exp_n) begin
      bad = 0;
      for (int k = 0; k < int'(v.cnt); k++)
        if (beats[k+1] != {2'b00, pay(v.addr, k)}) bad++;
      chk(bad == 0, "R3 payload bytes low-first", bad, 0);
      chk(beats[exp_n-1] == 10'h300, "R2 crc beat last", beats[exp_n-1], 10'h300);
    end
    chk(ep_stat == v.xst, {req, " status after"}, ep_stat, v.xst);
    chk(ep_tog == (v.tg ^ v.xflip), {req, " toggle after"}, ep_tog, v.tg ^ v.xflip);
    chk(xfer_done == v.xflip, {req, " done after"}, xfer_done, v.xflip);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++)
      mem[i] = {8'(i * 7 + 3), 8'(i ^ 8'h5C)};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ep_stat == 2'b00, "R1 status", ep_stat, 0);
    chk(ep_tog == 1'b0, "R1 toggle", ep_tog, 0);
    chk(xfer_done == 1'b0, "R1 done", xfer_done, 0);
    chk(tx_valid == 1'b0, "R1 no beat", tx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < NV; n++) begin
      run(VECS[n], 1'b0);
      judge(VECS[n], $sformatf("R2/R5/R7 vec%0d", n));
    end

    // R6: disabled endpoint touches no memory (last disabled run)
    arm(2'b00, 1'b0);
    nrd = 0; nb = 0;
    pulse_tok;
    repeat (20) @(negedge clk);
    chk(nrd == 0 && nb == 0, "R6 no read no beat", nrd + nb, 0);

    // R10: tokens during packet and during ack window are ignored
    run('{2'b11, 1'b0, 16'h0010, 16'd6, 2'd1, 1'b1, 8'd8, 8'hC3, 2'b10, 1'b1}, 1'b1);
    judge('{2'b11, 1'b0, 16'h0010, 16'd6, 2'd1, 1'b1, 8'd8, 8'hC3, 2'b10, 1'b1}, "R10 busy token");

    // R11: done_clr clears the flag without touching status
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    @(negedge clk);
    chk(xfer_done == 1'b0, "R11 done cleared", xfer_done, 0);
    chk(ep_stat == 2'b10, "R11 status kept", ep_stat, 2);

    // R11/R7: ACK in the same cycle as arm wins
    run('{2'b11, 1'b1, 16'h0030, 16'd2, 2'd0, 1'b0, 8'd4, 8'h4B, 2'b11, 1'b0}, 1'b0);
    arm(2'b11, 1'b1);
    mem[1] = 16'd1;
    nb = 0; seen_last = 1'b0;
    pulse_tok;
    for (int i = 0; i < 300 && !seen_last; i++) @(negedge clk);
    @(negedge clk);
    ack_in = 1'b1; arm_we = 1'b1; arm_stat = 2'b11; arm_tog = 1'b1;
    @(negedge clk);
    ack_in = 1'b0; arm_we = 1'b0;
    @(negedge clk);
    chk(ep_stat == 2'b10 && ep_tog == 1'b0 && xfer_done, "R11 ack beats arm",
        {ep_stat, ep_tog, xfer_done}, 4'b1001);

    // R5: after ACK the next token is NAKed
    repeat (ACK_WIN + 4) @(negedge clk);
    nb = 0; seen_last = 1'b0;
    pulse_tok;
    repeat (10) @(negedge clk);
    chk(nb == 1 && beats[0] == 10'h15A, "R5 nak after ack", beats[0], 10'h15A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule